// File: doc/BRIEF.md
# Low-Power Bus Turnaround Controller

This block moves ownership of a bidirectional low-power line pair from one end of a serial link to the other. While it owns the lane it holds the stop state. When asked to give the lane away it sends a fixed entry pattern, drives a bridge state and then stops driving. From then on it listens. When it sees the far end's handover pattern it waits a short fixed time, drives its own bridge state and takes the lane back. It then holds stop again and raises its ownership flag.

All durations come from one configured low-power period length L, counted in clock cycles. L is clamped to a parameterised minimum of 10 cycles, which is 50 ns at 200 MHz.

The line pair is written {P,N}. The codes are: stop = 2'b11, high-low marker = 2'b10, bridge/low = 2'b00. The code 2'b01 is never driven.

Each state has its own output and duration:

| State | Output | Duration |
|---|---|---|
| `ST_OWN` | owner, drives stop | no limit |
| `ST_TX_STOP` | stop | L |
| `ST_TX_ESC_A` | 10 | L |
| `ST_TX_LOW_A` | 00 | L |
| `ST_TX_ESC_B` | 10 | L |
| `ST_TX_LOW_B` | 00 | L |
| `ST_TX_BRIDGE` | 00 | 4L |
| `ST_LISTEN` | released | T cycles |
| `ST_STALL` | released, timed out | no limit |
| `ST_IDLE_RX` | released | no limit; reset state when `INIT_OWNER`=0 |
| `ST_SURE` | released | L+ceil(L/2) |
| `ST_RX_BRIDGE` | 00 | 5L |

The transitions are:
- `ST_OWN`→`ST_TX_STOP` on a request.
- Each timed transmit state passes to the next when its count runs out: `ST_TX_STOP`→`ST_TX_ESC_A`→`ST_TX_LOW_A`→`ST_TX_ESC_B`→`ST_TX_LOW_B`→`ST_TX_BRIDGE`→`ST_LISTEN`.
- `ST_LISTEN`→`ST_SURE` on a 10 input.
- `ST_LISTEN`→`ST_STALL` when T cycles pass with no 10 input.
- `ST_STALL`→`ST_SURE` and `ST_IDLE_RX`→`ST_SURE` on a 10 input.
- `ST_SURE`→`ST_RX_BRIDGE` when the wait ends.
- `ST_RX_BRIDGE`→`ST_OWN` when the bridge ends.

Top module: `lp_turnaround_ctrl`

## Requirements
- R1: During and right after reset (default `INIT_OWNER`=1) owner_o=1, drive_en_o=1, line_o=2'b11 and timeout_o=0.
- R2: A req_i seen high while owning starts this sequence on the next cycle, with drive_en_o=1 and owner_o=1 throughout: 2'b11 for L cycles, 2'b10 for L, 2'b00 for L, 2'b10 for L, 2'b00 for L, then 2'b00 for 4L cycles. The code 2'b01 is never driven.
- R3: In the cycle after the 4L bridge, drive_en_o=0 and owner_o=0. While not driving, line_o reads 2'b11.
- R4: Once line_i=2'b10 is sampled while listening, the outputs stay released for L+ceil(L/2) cycles. Then line_o=2'b00 with drive_en_o=1 for 5L cycles. Then line_o=2'b11 and owner_o=1.
- R5: If T cycles of listening pass without line_i=2'b10, timeout_o rises and stays high until 2'b10 is sampled. The block still answers that 2'b10. A T of 0 acts as 1.
- R6: An lpx_cycles_i below LPX_MIN (10) behaves exactly as LPX_MIN.
- R7: req_i has no effect while the lane is released.
- R8: line_i has no effect while the block owns the lane.
- R9: req_i held high during the send sequence neither restarts nor lengthens it.
- R10: owner_o=1 always implies drive_en_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lpx_cycles_i | input | CW | Low-power period length in cycles |
| timeout_cycles_i | input | TW | Listening limit T in cycles |
| req_i | input | 1 | Request to hand the lane over |
| line_i | input | 2 | Sampled line pair {P,N} |
| line_o | output | 2 | Driven line pair {P,N} |
| drive_en_o | output | 1 | Output enable for the line pair |
| owner_o | output | 1 | Lane ownership flag |
| timeout_o | output | 1 | No response from the far end |

## Verification
The assertions assume that line_i is already synchronised to clk_i and that lpx_cycles_i and timeout_cycles_i stay unchanged during a handover. The stimulus changes those settings only while the block owns the lane. It drives every input on the falling edge. The far end's 2'b10 is sent only while the block is listening or stalled, never during the sequences, so ownership changes only at the release and at the end of the receive bridge.

// File: rtl/lpta_pkg.sv
package lpta_pkg;

    typedef enum logic [3:0] {
        ST_OWN,
        ST_TX_STOP,
        ST_TX_ESC_A,
        ST_TX_LOW_A,
        ST_TX_ESC_B,
        ST_TX_LOW_B,
        ST_TX_BRIDGE,
        ST_LISTEN,
        ST_STALL,
        ST_IDLE_RX,
        ST_SURE,
        ST_RX_BRIDGE
    } lpta_state_e;

    localparam logic [1:0] LP_STOP   = 2'b11;
    localparam logic [1:0] LP_HI_LO  = 2'b10;
    localparam logic [1:0] LP_BRIDGE = 2'b00;

endpackage

// File: rtl/lpta_dur_calc.sv
module lpta_dur_calc #(
    parameter int CW      = 8,
    parameter int TW      = 16,
    parameter int LPX_MIN = 10,
    parameter int KW      = 16
) (
    input  logic [CW-1:0] lpx_i,
    input  logic [TW-1:0] tmo_i,
    output logic [KW-1:0] lpx_m1_o,
    output logic [KW-1:0] quad_m1_o,
    output logic [KW-1:0] quint_m1_o,
    output logic [KW-1:0] wait_m1_o,
    output logic [KW-1:0] tmo_m1_o
);

    logic [KW-1:0] raw_len;
    logic [KW-1:0] eff_len;
    logic [KW-1:0] quad_len;
    logic [KW-1:0] quint_len;
    logic [KW-1:0] half_up;

    always_comb begin
        // Clamp the period to its floor, then derive every multiple from it.
        raw_len    = KW'(lpx_i);
        eff_len    = (raw_len < KW'(LPX_MIN)) ? KW'(LPX_MIN) : raw_len;
        quad_len   = eff_len << 2;
        quint_len  = quad_len + eff_len;
        half_up    = (eff_len + KW'(1)) >> 1;
        lpx_m1_o   = eff_len - KW'(1);
        quad_m1_o  = quad_len - KW'(1);
        quint_m1_o = quint_len - KW'(1);
        wait_m1_o  = eff_len + half_up - KW'(1);
        tmo_m1_o   = (tmo_i == '0) ? '0 : (KW'(tmo_i) - KW'(1));
    end

endmodule

// File: rtl/lpta_timer.sv
module lpta_timer #(
    parameter int KW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [KW-1:0] val_i,
    output logic          done_o
);

    logic [KW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - KW'(1);
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lpta_fsm.sv
module lpta_fsm
    import lpta_pkg::*;
#(
    parameter int KW         = 16,
    parameter bit INIT_OWNER = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic [1:0]    line_i,
    input  logic          done_i,
    input  logic [KW-1:0] lpx_m1_i,
    input  logic [KW-1:0] quad_m1_i,
    input  logic [KW-1:0] quint_m1_i,
    input  logic [KW-1:0] wait_m1_i,
    input  logic [KW-1:0] tmo_m1_i,
    output logic          load_o,
    output logic [KW-1:0] load_val_o,
    output logic [1:0]    line_o,
    output logic          oe_o,
    output logic          owner_o,
    output logic          timeout_o
);

    localparam lpta_state_e RESET_ST = INIT_OWNER ? ST_OWN : ST_IDLE_RX;

    lpta_state_e state_q;
    lpta_state_e state_d;
    logic        far_marker;

    assign far_marker = (line_i == LP_HI_LO);

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= RESET_ST;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN:       if (req_i)      state_d = ST_TX_STOP;
            ST_TX_STOP:   if (done_i)     state_d = ST_TX_ESC_A;
            ST_TX_ESC_A:  if (done_i)     state_d = ST_TX_LOW_A;
            ST_TX_LOW_A:  if (done_i)     state_d = ST_TX_ESC_B;
            ST_TX_ESC_B:  if (done_i)     state_d = ST_TX_LOW_B;
            ST_TX_LOW_B:  if (done_i)     state_d = ST_TX_BRIDGE;
            ST_TX_BRIDGE: if (done_i)     state_d = ST_LISTEN;
            ST_LISTEN: begin
                if (far_marker)           state_d = ST_SURE;
                else if (done_i)          state_d = ST_STALL;
            end
            ST_STALL:     if (far_marker) state_d = ST_SURE;
            ST_IDLE_RX:   if (far_marker) state_d = ST_SURE;
            ST_SURE:      if (done_i)     state_d = ST_RX_BRIDGE;
            ST_RX_BRIDGE: if (done_i)     state_d = ST_OWN;
            default:                      state_d = RESET_ST;
        endcase
    end

    // Timer reload on every state change, with the duration of the state entered
    always_comb begin
        load_o = (state_d != state_q);
        unique case (state_d)
            ST_TX_BRIDGE: load_val_o = quad_m1_i;
            ST_RX_BRIDGE: load_val_o = quint_m1_i;
            ST_SURE:      load_val_o = wait_m1_i;
            ST_LISTEN:    load_val_o = tmo_m1_i;
            default:      load_val_o = lpx_m1_i;
        endcase
    end

    // Moore outputs
    always_comb begin
        line_o    = LP_STOP;
        oe_o      = 1'b0;
        owner_o   = 1'b0;
        timeout_o = 1'b0;
        unique case (state_q)
            ST_OWN, ST_TX_STOP: begin
                oe_o    = 1'b1;
                owner_o = 1'b1;
            end
            ST_TX_ESC_A, ST_TX_ESC_B: begin
                line_o  = LP_HI_LO;
                oe_o    = 1'b1;
                owner_o = 1'b1;
            end
            ST_TX_LOW_A, ST_TX_LOW_B, ST_TX_BRIDGE: begin
                line_o  = LP_BRIDGE;
                oe_o    = 1'b1;
                owner_o = 1'b1;
            end
            ST_RX_BRIDGE: begin
                line_o = LP_BRIDGE;
                oe_o   = 1'b1;
            end
            ST_STALL:   timeout_o = 1'b1;
            ST_LISTEN, ST_IDLE_RX, ST_SURE: begin
                oe_o = 1'b0;
            end
            default: begin
                oe_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lp_turnaround_ctrl.sv
module lp_turnaround_ctrl #(
    parameter int CW         = 8,
    parameter int TW         = 16,
    parameter int LPX_MIN    = 10,
    parameter bit INIT_OWNER = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] lpx_cycles_i,
    input  logic [TW-1:0] timeout_cycles_i,
    input  logic          req_i,
    input  logic [1:0]    line_i,
    output logic [1:0]    line_o,
    output logic          drive_en_o,
    output logic          owner_o,
    output logic          timeout_o
);

    localparam int DW = CW + 3;
    localparam int KW = (DW > TW) ? DW : TW;

    logic [KW-1:0] lpx_m1;
    logic [KW-1:0] quad_m1;
    logic [KW-1:0] quint_m1;
    logic [KW-1:0] wait_m1;
    logic [KW-1:0] tmo_m1;
    logic          tmr_load;
    logic [KW-1:0] tmr_val;
    logic          tmr_done;

    lpta_dur_calc #(
        .CW      (CW),
        .TW      (TW),
        .LPX_MIN (LPX_MIN),
        .KW      (KW)
    ) u_dur (
        .lpx_i      (lpx_cycles_i),
        .tmo_i      (timeout_cycles_i),
        .lpx_m1_o   (lpx_m1),
        .quad_m1_o  (quad_m1),
        .quint_m1_o (quint_m1),
        .wait_m1_o  (wait_m1),
        .tmo_m1_o   (tmo_m1)
    );

    lpta_timer #(
        .KW (KW)
    ) u_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    lpta_fsm #(
        .KW         (KW),
        .INIT_OWNER (INIT_OWNER)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req_i),
        .line_i     (line_i),
        .done_i     (tmr_done),
        .lpx_m1_i   (lpx_m1),
        .quad_m1_i  (quad_m1),
        .quint_m1_i (quint_m1),
        .wait_m1_i  (wait_m1),
        .tmo_m1_i   (tmo_m1),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .line_o     (line_o),
        .oe_o       (drive_en_o),
        .owner_o    (owner_o),
        .timeout_o  (timeout_o)
    );

endmodule

// File: rtl/lpta_checker.sv
module lpta_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] line_i,
    input logic [1:0] line_o,
    input logic       drive_en_o,
    input logic       owner_o,
    input logic       timeout_o
);

    // R10
    p_owner_drives_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        owner_o |-> drive_en_o);

    // R2
    p_no_lp01_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_en_o |-> (line_o != 2'b01));

    // R3
    p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(owner_o) |-> (!drive_en_o && $past(drive_en_o) && ($past(line_o) == 2'b00)));

    // R4
    p_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(owner_o) |-> ((line_o == 2'b11) && $past(drive_en_o) && ($past(line_o) == 2'b00)));

    // R5
    p_stall_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> (!drive_en_o && !owner_o));

    // R5
    p_timeout_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(timeout_o) |-> ($past(line_i) == 2'b10));

endmodule

bind lp_turnaround_ctrl lpta_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .line_o     (line_o),
    .drive_en_o (drive_en_o),
    .owner_o    (owner_o),
    .timeout_o  (timeout_o)
);

// File: tb/lp_turnaround_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_turnaround_ctrl_tb_top;

    localparam int CW      = 8;
    localparam int TW      = 16;
    localparam int LPX_MIN = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] lpx = CW'(LPX_MIN);
    logic [TW-1:0] tmo = TW'(20);
    logic          req = 1'b0;
    logic [1:0]    line_in = 2'b11;
    logic [1:0]    line_out;
    logic          oe;
    logic          owner;
    logic          tmo_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lp_turnaround_ctrl #(
        .CW      (CW),
        .TW      (TW),
        .LPX_MIN (LPX_MIN)
    ) dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .lpx_cycles_i     (lpx),
        .timeout_cycles_i (tmo),
        .req_i            (req),
        .line_i           (line_in),
        .line_o           (line_out),
        .drive_en_o       (oe),
        .owner_o          (owner),
        .timeout_o        (tmo_flag)
    );

    function automatic int eff_len(int raw);
        return (raw < LPX_MIN) ? LPX_MIN : raw;
    endfunction

    function automatic int wait_len(int l);
        return l + (l + 1) / 2;
    endfunction

    function automatic logic [1:0] tx_code(int i, int l);
        case (i / l)
            0:       return 2'b11;
            1:       return 2'b10;
            2:       return 2'b00;
            3:       return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // expected vector: {owner, drive_en, line[1:0], timeout}
    task automatic cmp(string rq, logic [4:0] exp);
        logic [4:0] act;
        act = {owner, oe, line_out, tmo_flag};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t: got %b expected %b (owner,oe,line,timeout)", rq, $time, act, exp);
        end
    endtask

    task automatic handover(int raw, int t, int j, bit hold_req, bit poke);
        int l;
        int w;
        int te;
        string tag;
        l   = eff_len(raw);
        w   = wait_len(l);
        te  = (t == 0) ? 1 : t;
        tag = (raw < LPX_MIN) ? "R6" : (hold_req ? "R9" : "R2");
        @(negedge clk);
        lpx = CW'(raw);
        tmo = TW'(t);
        req = 1'b1;
        // R2/R6/R9 send sequence
        for (int i = 0; i < 9 * l; i++) begin
            @(negedge clk);
            if (i == 0 && !hold_req) req = 1'b0;
            cmp(tag, {1'b1, 1'b1, tx_code(i, l), 1'b0});
        end
        // R3 release
        @(negedge clk);
        req = 1'b0;
        cmp("R3", {1'b0, 1'b0, 2'b11, 1'b0});
        // listening, R5 timeout and R7 ignored requests
        for (int m = 1; m <= j; m++) begin
            @(negedge clk);
            cmp((m >= te) ? "R5" : (poke ? "R7" : "R3"),
                {1'b0, 1'b0, 2'b11, (m >= te) ? 1'b1 : 1'b0});
            if (poke) req = m[0];
        end
        line_in = 2'b10;
        req = 1'b0;
        // R4 wait after the marker
        for (int s = 0; s < w; s++) begin
            @(negedge clk);
            if (s == 0) line_in = 2'b11;
            cmp("R4", {1'b0, 1'b0, 2'b11, 1'b0});
        end
        for (int r = 0; r < 5 * l; r++) begin
            @(negedge clk);
            cmp("R4", {1'b0, 1'b1, 2'b00, 1'b0});
        end
        @(negedge clk);
        cmp("R4", {1'b1, 1'b1, 2'b11, 1'b0});
    endtask

    task automatic marker_while_owner(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            line_in = (k == n - 1) ? 2'b11 : 2'b10;
            cmp("R8", {1'b1, 1'b1, 2'b11, 1'b0});
        end
        @(negedge clk);
        cmp("R8", {1'b1, 1'b1, 2'b11, 1'b0});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1a2b_3c4d);
        repeat (3) @(negedge clk);
        cmp("R1", {1'b1, 1'b1, 2'b11, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1", {1'b1, 1'b1, 2'b11, 1'b0});
        marker_while_owner(5);
        handover(3, 5, 2, 1'b0, 1'b0);       // R6 clamp
        handover(LPX_MIN, 4, 9, 1'b0, 1'b0); // R5 timeout
        handover(17, 20, 19, 1'b1, 1'b1);    // R9, R7, odd L wait
        handover(12, 0, 3, 1'b0, 1'b0);      // R5 T of 0
        handover(11, 11, 10, 1'b0, 1'b1);    // marker at last listen cycle
        marker_while_owner(3);
        for (int it = 0; it < 8; it++) begin
            int rl;
            int rt;
            int rj;
            rl = int'($urandom_range(24, 1));
            rt = int'($urandom_range(40, 1));
            rj = int'($urandom_range(rt + 5, 0));
            handover(rl, rt, rj, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

endmodule